// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block sits in the execute stage of a 32-bit RISC-V core and decides where the program goes next. It receives the address of the current instruction and the instruction's major opcode and 3-bit sub-function. It also receives both source register values and an immediate that an earlier stage has already sign-extended. From these it produces the next program counter, the return address (current PC plus four), a write enable for that return address and a flag that says control flow was redirected.

Conditional branches compare the two register operands under one of six conditions. When the condition holds, the PC moves by the immediate counted in halfwords. The direct jump uses the same halfword-scaled PC-relative target. The register-indirect jump adds the immediate to the first operand and clears bit 0 of the sum. Every other opcode falls through to PC+4. Branch sub-function codes that name no condition are reported on an error output. The block is purely combinational: outputs follow the inputs in the same cycle.

Top module: `npc_unit`

## Requirements
- R1: With opcode 1100011, funct3 000 redirects when rs1 equals rs2 and funct3 001 redirects when they differ.
- R2: With opcode 1100011, funct3 100 redirects when rs1 is less than rs2 as two's complement numbers, and funct3 101 redirects when it is greater or equal (e.g. 0xFFFFFFFF < 1 holds).
- R3: With opcode 1100011, funct3 110 redirects when rs1 is less than rs2 as unsigned magnitudes, and funct3 111 redirects when it is greater or equal (e.g. 0xFFFFFFFF < 1 does not hold).
- R4: A redirected branch gives next PC = PC + 2*imm, so an immediate of 64 advances 128 bytes. A branch whose condition fails gives PC+4 with taken low. Neither case asserts link-write.
- R5: Opcode 1101111 gives next PC = PC + 2*imm, link-write high and taken high.
- R6: Opcode 1100111 with funct3 000 gives next PC = (rs1 + imm) with bit 0 forced to 0, link-write high and taken high. The same opcode with any other funct3 is illegal: error high, PC+4, taken and link-write low.
- R7: Opcode 1100011 with funct3 010 or 011 raises the error output, gives PC+4, and keeps taken and link-write low.
- R8: The link output always equals PC+4. Link-write is high only for the two jump forms.
- R9: Every other opcode gives PC+4 with taken, link-write and error low.
- R10: All address sums wrap modulo 2^XLEN (e.g. PC 0xFFFFFFFC falls through to 0x00000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | Address of the current instruction |
| opcode_i | input | 7 | Major opcode field |
| funct3_i | input | 3 | Sub-function field |
| rs1_i | input | XLEN | First source operand value |
| rs2_i | input | XLEN | Second source operand value |
| imm_i | input | XLEN | Sign-extended immediate (halfword count for PC-relative forms) |
| npc_o | output | XLEN | Next program counter |
| link_o | output | XLEN | Return address, PC+4 |
| link_we_o | output | 1 | Return address must be written to rd |
| taken_o | output | 1 | Control flow redirected |
| illegal_o | output | 1 | Unknown branch or indirect-jump sub-function |

## Verification
The bench builds the unit with XLEN = 32 and the subtractor-based comparator. At that width the sign-boundary operands 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF can be reached, and they separate the signed and unsigned orderings. The same width lets PC and rs1 values near the top of the address space show that targets and the fall-through address wrap. Random opcodes are weighted toward the three control opcodes, and all eight branch sub-function codes are covered.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  // Upper two funct3 bits of a branch select the comparison; bit 0 inverts it.
  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_BAD = 2'b01,
    CMP_LTS = 2'b10,
    CMP_LTU = 2'b11
  } cmp_sel_e;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_BRANCH,
    FLOW_JAL,
    FLOW_JALR
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  output flow_e      flow_o,
  output cmp_sel_e   sel_o,
  output logic       invert_o,
  output logic       illegal_o
);
  always_comb begin
    flow_o    = FLOW_SEQ;
    sel_o     = cmp_sel_e'(funct3_i[2:1]);
    invert_o  = funct3_i[0];
    illegal_o = 1'b0;
    unique case (opcode_i)
      OPC_BRANCH: begin
        if (funct3_i[2:1] == CMP_BAD) illegal_o = 1'b1;
        else                          flow_o    = FLOW_BRANCH;
      end
      OPC_JAL:  flow_o = FLOW_JAL;
      OPC_JALR: begin
        if (funct3_i == 3'b000) flow_o    = FLOW_JALR;
        else                    illegal_o = 1'b1;
      end
      default: flow_o = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int XLEN    = 32,
  parameter bit USE_SUB = 1'b1
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            eq_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);
  localparam int MSB = XLEN - 1;

  assign eq_o = (a_i == b_i);

  generate
    if (USE_SUB) begin : g_sub
      logic [XLEN:0] diff;
      assign diff   = {1'b0, a_i} - {1'b0, b_i};
      assign lt_u_o = diff[XLEN];
    end else begin : g_rel
      assign lt_u_o = (a_i < b_i);
    end
  endgenerate

  // Differing signs: the negative one is smaller; equal signs: magnitude order.
  assign lt_s_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : lt_u_o;
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] rel_o,
  output logic [XLEN-1:0] ind_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] ind_sum;

  assign seq_o   = pc_i + STEP;
  assign rel_o   = pc_i + {imm_i[XLEN-2:0], 1'b0};
  assign ind_sum = rs1_i + imm_i;
  assign ind_o   = {ind_sum[XLEN-1:1], 1'b0};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit USE_SUB = 1'b1
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [6:0]      opcode_i,
  input  logic [2:0]      funct3_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] link_o,
  output logic            link_we_o,
  output logic            taken_o,
  output logic            illegal_o
);
  flow_e           flow;
  cmp_sel_e        sel;
  logic            invert;
  logic            eq, lt_s, lt_u;
  logic            cond, hit;
  logic [XLEN-1:0] seq_tgt, rel_tgt, ind_tgt;

  npc_decode u_decode (
    .opcode_i  (opcode_i),
    .funct3_i  (funct3_i),
    .flow_o    (flow),
    .sel_o     (sel),
    .invert_o  (invert),
    .illegal_o (illegal_o)
  );

  npc_cmp #(.XLEN(XLEN), .USE_SUB(USE_SUB)) u_cmp (
    .a_i    (rs1_i),
    .b_i    (rs2_i),
    .eq_o   (eq),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  npc_target #(.XLEN(XLEN)) u_target (
    .pc_i  (pc_i),
    .rs1_i (rs1_i),
    .imm_i (imm_i),
    .seq_o (seq_tgt),
    .rel_o (rel_tgt),
    .ind_o (ind_tgt)
  );

  always_comb begin
    unique case (sel)
      CMP_EQ:  cond = eq;
      CMP_LTS: cond = lt_s;
      CMP_LTU: cond = lt_u;
      default: cond = 1'b0;
    endcase
    hit = cond ^ invert;
  end

  assign link_o = seq_tgt;

  always_comb begin
    npc_o     = seq_tgt;
    taken_o   = 1'b0;
    link_we_o = 1'b0;
    unique case (flow)
      FLOW_BRANCH: begin
        taken_o = hit;
        if (hit) npc_o = rel_tgt;
      end
      FLOW_JAL: begin
        taken_o   = 1'b1;
        link_we_o = 1'b1;
        npc_o     = rel_tgt;
      end
      FLOW_JALR: begin
        taken_o   = 1'b1;
        link_we_o = 1'b1;
        npc_o     = ind_tgt;
      end
      default: npc_o = seq_tgt;
    endcase
  end

  always_comb begin
    // R8
    link_we_chk: assert (!link_we_o || taken_o)
      else $error("link write without redirect");
    // R7
    illegal_quiet_chk: assert (!illegal_o || (!taken_o && !link_we_o))
      else $error("illegal code redirected or linked");
    // R9
    fall_through_chk: assert (taken_o || (npc_o == link_o))
      else $error("not taken but next PC differs from PC+4");
    // R6
    jalr_lsb_chk: assert ((flow != FLOW_JALR) || !npc_o[0])
      else $error("indirect target has bit 0 set");
    // R4
    branch_even_chk: assert (!(flow == FLOW_BRANCH && taken_o && !pc_i[0]) || !npc_o[0])
      else $error("branch target lost halfword alignment");
  end
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  localparam int XLEN = 32;
  localparam logic [6:0] OB = 7'b1100011;
  localparam logic [6:0] OJ = 7'b1101111;
  localparam logic [6:0] OR = 7'b1100111;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [XLEN-1:0] pc, rs1, rs2, imm;
  logic [6:0]      opc;
  logic [2:0]      f3;
  logic [XLEN-1:0] npc, link;
  logic            lwe, tkn, ill;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  npc_unit #(.XLEN(XLEN), .USE_SUB(1'b1)) u_dut (
    .pc_i(pc), .opcode_i(opc), .funct3_i(f3), .rs1_i(rs1), .rs2_i(rs2),
    .imm_i(imm), .npc_o(npc), .link_o(link), .link_we_o(lwe),
    .taken_o(tkn), .illegal_o(ill)
  );

  function automatic string tag_of(logic [6:0] o, logic [2:0] f);
    if (o == OB) begin
      case (f)
        3'b000, 3'b001: return "R1";
        3'b100, 3'b101: return "R2";
        3'b110, 3'b111: return "R3";
        default:        return "R7";
      endcase
    end
    if (o == OJ) return "R5";
    if (o == OR) return "R6";
    return "R9";
  endfunction

  task automatic apply(input logic [6:0] o, input logic [2:0] f,
                       input logic [31:0] p, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] i,
                       input string tag);
    logic [31:0] e_seq, e_npc;
    logic e_lwe, e_tkn, e_ill, c;
    @(negedge clk);
    opc = o; f3 = f; pc = p; rs1 = a; rs2 = b; imm = i;
    e_seq = p + 32'd4;
    e_npc = e_seq; e_lwe = 0; e_tkn = 0; e_ill = 0;
    if (o == OB) begin
      case (f)
        3'b000: c = (a == b);
        3'b001: c = (a != b);
        3'b100: c = ($signed(a) <  $signed(b));
        3'b101: c = ($signed(a) >= $signed(b));
        3'b110: c = (a <  b);
        3'b111: c = (a >= b);
        default: begin c = 0; e_ill = 1; end
      endcase
      if (c) begin e_tkn = 1; e_npc = p + i * 32'd2; end
    end else if (o == OJ) begin
      e_tkn = 1; e_lwe = 1; e_npc = p + i * 32'd2;
    end else if (o == OR) begin
      if (f == 3'b000) begin
        e_tkn = 1; e_lwe = 1; e_npc = (a + i) & 32'hFFFF_FFFE;
      end else e_ill = 1;
    end
    #1;
    checks++;
    if (npc !== e_npc || link !== e_seq || lwe !== e_lwe ||
        tkn !== e_tkn || ill !== e_ill) begin
      errors++;
      $display("FAIL %s: opc=%b f3=%b got npc=%h link=%h we=%b tk=%b il=%b exp npc=%h link=%h we=%b tk=%b il=%b",
               tag, o, f, npc, link, lwe, tkn, ill, e_npc, e_seq, e_lwe, e_tkn, e_ill);
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    opc = '0; f3 = '0; pc = '0; rs1 = '0; rs2 = '0; imm = '0;
    // R9 initial non-control state
    apply(7'b0010011, 3'b000, 32'h0000_1000, 32'd0, 32'd0, 32'd0, "R9");
    // R1 equal / not equal
    apply(OB, 3'b000, 32'h100, 32'd7, 32'd7, 32'd8, "R1");
    apply(OB, 3'b000, 32'h100, 32'd7, 32'd6, 32'd8, "R1");
    apply(OB, 3'b001, 32'h100, 32'd7, 32'd6, 32'hFFFF_FFF8, "R1");
    // R2 signed: 0xFFFFFFFF < 1
    apply(OB, 3'b100, 32'h200, 32'hFFFF_FFFF, 32'd1, 32'd16, "R2");
    apply(OB, 3'b101, 32'h200, 32'h8000_0000, 32'h7FFF_FFFF, 32'd16, "R2");
    apply(OB, 3'b101, 32'h200, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'd16, "R2");
    // R3 unsigned: 0xFFFFFFFF not < 1
    apply(OB, 3'b110, 32'h300, 32'hFFFF_FFFF, 32'd1, 32'd16, "R3");
    apply(OB, 3'b111, 32'h300, 32'hFFFF_FFFF, 32'd1, 32'd16, "R3");
    apply(OB, 3'b110, 32'h300, 32'h7FFF_FFFF, 32'h8000_0000, 32'd16, "R3");
    // R4 offset 64 moves 128 bytes
    apply(OB, 3'b000, 32'h400, 32'd0, 32'd0, 32'd64, "R4");
    // R5 jal backward
    apply(OJ, 3'b010, 32'h1000, 32'd0, 32'd0, 32'hFFFF_FF00, "R5");
    // R6 jalr odd sum, and illegal funct3
    apply(OR, 3'b000, 32'h500, 32'h0000_2001, 32'd0, 32'd16, "R6");
    apply(OR, 3'b011, 32'h500, 32'h0000_2001, 32'd0, 32'd16, "R6");
    // R7 illegal branch codes
    apply(OB, 3'b010, 32'h600, 32'd1, 32'd1, 32'd8, "R7");
    apply(OB, 3'b011, 32'h600, 32'd1, 32'd2, 32'd8, "R7");
    // R8 link value on store opcode, no link write
    apply(7'b0100011, 3'b010, 32'h700, 32'd3, 32'd4, 32'd5, "R8");
    // R10 wrap-around
    apply(7'b0110111, 3'b000, 32'hFFFF_FFFC, 32'd0, 32'd0, 32'd0, "R10");
    apply(OJ, 3'b000, 32'hFFFF_FFF0, 32'd0, 32'd0, 32'd16, "R10");
    apply(OR, 3'b000, 32'h0, 32'hFFFF_FFFF, 32'd0, 32'd4, "R10");
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [6:0]  o;
      logic [2:0]  f;
      logic [31:0] a, b, r;
      r = $urandom;
      case (r[1:0])
        2'd0, 2'd1: o = OB;
        2'd2:       o = r[2] ? OJ : OR;
        default:    o = 7'($urandom);
      endcase
      f = 3'($urandom);
      if (o == OR && r[3]) f = 3'b000;
      a = $urandom;
      b = r[4] ? a : $urandom;
      if (r[5]) b = {~a[31], b[30:0]};
      apply(o, f, $urandom, a, b, $urandom, tag_of(o, f));
    end
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule